// File: doc/BRIEF.md
# Text-Mode Character and Color Buffer

This block is the processor side of a character-cell display of 100 columns and 75 rows, so 7500 cells. Each cell has two stored values. One is a character code of 8 bits. The other is a color index of 4 bits, which selects one of 16 colors. The two values are kept in separate storage planes. Each plane has its own fixed address window on the system bus.

A bus store is decoded against both windows. A store that hits a window writes the cell whose index equals the byte offset from that window's base. Cells are laid out row-major, so the index is row*100 + column. The processor cannot read either plane back. A second port, used only by a scan-out engine, takes a cell index and returns the character and color of that cell one clock later.

After reset the block runs a clearing sweep. The sweep writes a space (0x20) and color 0 into every cell, one cell per clock. Bus stores are ignored until the sweep finishes.

Top module: `textPlaneWriter`

## Requirements
- R1: Starting at the first clock after reset is released, an internal sweep writes one cell per clock, in rising index order. Within 7500 clocks every cell reads back as character 0x20 with color 0.
- R2: A store (busValid=1, busWrite=1) to an address from 0x8000C000 to 0x8000DD4B writes busData[7:0] into the character plane. The target cell index is address minus 0x8000C000, which equals row*100 + column.
- R3: A store to an address from 0x8000E000 to 0x8000FD4B writes busData[3:0] into the color plane at index address minus 0x8000E000. Bits busData[7:4] are discarded.
- R4: A bus access with busWrite=0 changes neither plane.
- R5: A store whose offset within either window is 7500 or more changes neither plane. This covers addresses 0x8000DD4C to 0x8000DFFF and 0x8000FD4C to 0x8000FFFF.
- R6: A store to an address outside both windows changes neither plane.
- R7: The scan port is registered. The scanChar and scanColor values present after a clock edge belong to the scanCell value applied before that edge. A new cell can be requested every clock.
- R8: When the scan port reads a cell in the same clock that a store writes it, the scan port returns the contents from before that store.
- R9: A character store leaves the cell's color unchanged, and a color store leaves the cell's character unchanged.
- R10: A store issued while the post-reset sweep is running is ignored, whatever its address.
- R11: A scan request for an index of 7500 or more returns character 0x20 and color 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access present this clock |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | 32 | Byte address of the access |
| busData | input | 8 | Store data |
| scanCell | input | 13 | Cell index requested by the scan-out engine |
| scanChar | output | 8 | Character code of the cell requested in the previous clock |
| scanColor | output | 4 | Color index of the cell requested in the previous clock |

## Verification
Wrong state in this block shows up only through the scan port, one clock after a request. A stray or misdecoded write stays hidden until the damaged cell is scanned. The bench therefore reads back every cell after the sweep. After each group of stores or rejected accesses, it scans the cells those accesses could have touched, including the cells in both planes. A sweep counter that skips cells or stops early leaves cells that are not blank, and the full readback finds them. A read that returns the wrong side of a same-cycle write is caught by the read-during-write check.

// File: rtl/dispPkg.sv
package dispPkg;
  localparam int COLS    = 100;
  localparam int ROWS    = 75;
  localparam int CELLS   = COLS * ROWS;
  localparam int IDX_W   = $clog2(CELLS);
  localparam int CHAR_W  = 8;
  localparam int COLOR_W = 4;
  localparam int ADDR_W  = 32;
  localparam int WIN_W   = 13;

  localparam logic [ADDR_W-1:0]  CHAR_BASE   = 32'h8000_C000;
  localparam logic [ADDR_W-1:0]  COLOR_BASE  = 32'h8000_E000;
  localparam logic [CHAR_W-1:0]  BLANK_CHAR  = 8'h20;
  localparam logic [COLOR_W-1:0] BLANK_COLOR = '0;

  typedef enum logic {ST_CLEAR, ST_RUN} phase_t;

  typedef struct packed {
    logic               charWe;
    logic               colorWe;
    logic [IDX_W-1:0]   idx;
    logic [CHAR_W-1:0]  chr;
    logic [COLOR_W-1:0] col;
  } planeStrb_t;
endpackage

// File: rtl/dispPlane.sv
module dispPlane #(
  parameter int               WIDTH = 8,
  parameter int               DEPTH = 7500,
  parameter int               IW    = 13,
  parameter logic [WIDTH-1:0] FILL  = '0
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    wIdx,
  input  logic [WIDTH-1:0] wData,
  input  logic [IW-1:0]    rIdx,
  output logic [WIDTH-1:0] rData
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first: the read samples the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (we) mem[wIdx] <= wData;
    if (rIdx < IW'(DEPTH)) rData <= mem[rIdx];
    else                   rData <= FILL;
  end
endmodule

// File: rtl/dispCtrl.sv
module dispCtrl
  import dispPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CHAR_W-1:0] busData,
  output planeStrb_t        strb,
  output logic              clearing
);
  phase_t           phase;
  logic [IDX_W-1:0] clrIdx;
  logic [WIN_W-1:0] offset;
  logic             hitChar, hitColor, inRange, storeOk;

  assign offset   = busAddr[WIN_W-1:0];
  assign hitChar  = busAddr[ADDR_W-1:WIN_W] == CHAR_BASE[ADDR_W-1:WIN_W];
  assign hitColor = busAddr[ADDR_W-1:WIN_W] == COLOR_BASE[ADDR_W-1:WIN_W];
  assign inRange  = offset < WIN_W'(CELLS);
  assign storeOk  = busValid && busWrite && inRange;
  assign clearing = (phase == ST_CLEAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_CLEAR;
      clrIdx <= '0;
    end else if (phase == ST_CLEAR) begin
      clrIdx <= clrIdx + 1'b1;
      if (clrIdx == IDX_W'(CELLS - 1)) phase <= ST_RUN;
    end
  end

  always_comb begin
    if (clearing) begin
      strb.charWe  = 1'b1;
      strb.colorWe = 1'b1;
      strb.idx     = clrIdx;
      strb.chr     = BLANK_CHAR;
      strb.col     = BLANK_COLOR;
    end else begin
      strb.charWe  = storeOk && hitChar;
      strb.colorWe = storeOk && hitColor;
      strb.idx     = IDX_W'(offset);
      strb.chr     = busData;
      strb.col     = busData[COLOR_W-1:0];
    end
  end
endmodule

// File: rtl/dispDatapath.sv
module dispDatapath
  import dispPkg::*;
(
  input  logic               clk,
  input  planeStrb_t         strb,
  input  logic [IDX_W-1:0]   scanCell,
  output logic [CHAR_W-1:0]  scanChar,
  output logic [COLOR_W-1:0] scanColor
);
  dispPlane #(
    .WIDTH(CHAR_W), .DEPTH(CELLS), .IW(IDX_W), .FILL(BLANK_CHAR)
  ) charPlane (
    .clk(clk), .we(strb.charWe), .wIdx(strb.idx), .wData(strb.chr),
    .rIdx(scanCell), .rData(scanChar)
  );

  dispPlane #(
    .WIDTH(COLOR_W), .DEPTH(CELLS), .IW(IDX_W), .FILL(BLANK_COLOR)
  ) colorPlane (
    .clk(clk), .we(strb.colorWe), .wIdx(strb.idx), .wData(strb.col),
    .rIdx(scanCell), .rData(scanColor)
  );
endmodule

// File: rtl/textPlaneWriter.sv
module textPlaneWriter
  import dispPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CHAR_W-1:0]  busData,
  input  logic [IDX_W-1:0]   scanCell,
  output logic [CHAR_W-1:0]  scanChar,
  output logic [COLOR_W-1:0] scanColor
);
  planeStrb_t ctrlStrb;
  logic       clearing;

  dispCtrl ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busData(busData), .strb(ctrlStrb), .clearing(clearing)
  );

  dispDatapath dpath (
    .clk(clk), .strb(ctrlStrb), .scanCell(scanCell),
    .scanChar(scanChar), .scanColor(scanColor)
  );
endmodule

// File: rtl/dispChecker.sv
module dispChecker
  import dispPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CHAR_W-1:0] busData,
  input planeStrb_t        strb,
  input logic              clearing
);
  logic outside;
  assign outside = (busAddr < CHAR_BASE) || (busAddr >= COLOR_BASE + 32'h2000) ||
                   ((busAddr >= CHAR_BASE + 32'h2000) && (busAddr < COLOR_BASE));

  a_r1_sweep_step: assert property (@(posedge clk) disable iff (!rstN)
    (clearing && strb.idx != '0) |->
      (strb.idx == $past(strb.idx) + 1'b1) && strb.charWe && strb.colorWe &&
      strb.chr == 8'h20 && strb.col == 4'h0);

  a_r3_color_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (!clearing && strb.colorWe) |-> strb.col == busData[3:0]);

  a_r4_load_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!clearing && busValid && !busWrite) |-> !strb.charWe && !strb.colorWe);

  a_r5_index_range: assert property (@(posedge clk) disable iff (!rstN)
    (strb.charWe || strb.colorWe) |-> strb.idx < IDX_W'(CELLS));

  a_r6_outside_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!clearing && outside) |-> !strb.charWe && !strb.colorWe);

  a_r9_one_plane: assert property (@(posedge clk) disable iff (!rstN)
    !clearing |-> !(strb.charWe && strb.colorWe));

  a_r10_store_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (clearing && busValid && busWrite) |-> strb.idx != busAddr[IDX_W-1:0] || strb.chr == 8'h20);
endmodule

bind textPlaneWriter dispChecker chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busData(busData), .strb(ctrlStrb), .clearing(clearing)
);

// File: tb/textPlaneWriter_test.sv
module textPlaneWriter_test;
  import dispPkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busValid, busWrite;
  logic [31:0] busAddr;
  logic [7:0]  busData;
  logic [12:0] scanCell;
  logic [7:0]  scanChar;
  logic [3:0]  scanColor;

  always #2 clk = ~clk;

  textPlaneWriter uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busData(busData), .scanCell(scanCell),
    .scanChar(scanChar), .scanColor(scanColor)
  );

  localparam logic [31:0] CB  = 32'h8000_C000;
  localparam logic [31:0] KB  = 32'h8000_E000;

  logic [7:0] expChar [7500];
  logic [3:0] expColor[7500];
  logic [7:0] qChar[$];
  logic [3:0] qColor[$];
  int         qIdx[$];
  string      qTag[$];
  int  errors = 0, checks = 0, cycles = 0;
  bit  finished = 0, sweepPhase = 0;

  function automatic void modelStore(logic [31:0] a, logic [7:0] d);
    if (sweepPhase) return;                       // R10
    if (a >= 32'h8000_C000 && a <= 32'h8000_DD4B) expChar[int'(a - CB)] = d;      // R2
    else if (a >= 32'h8000_E000 && a <= 32'h8000_FD4B) expColor[int'(a - KB)] = d[3:0]; // R3
  endfunction

  function automatic void pushExp(int idx, string tag);
    if (idx < 7500) begin qChar.push_back(expChar[idx]); qColor.push_back(expColor[idx]); end
    else begin qChar.push_back(8'h20); qColor.push_back(4'h0); end   // R11
    qIdx.push_back(idx);
    qTag.push_back(tag);
  endfunction

  task automatic store(logic [31:0] a, logic [7:0] d);
    busValid = 1; busWrite = 1; busAddr = a; busData = d;
    modelStore(a, d);
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic load(logic [31:0] a, logic [7:0] d);
    busValid = 1; busWrite = 0; busAddr = a; busData = d;
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic scan(int idx, string tag);
    scanCell = 13'(idx);
    pushExp(idx, tag);
    @(negedge clk);
  endtask

  task automatic storeScan(logic [31:0] a, logic [7:0] d, int idx, string tag);
    pushExp(idx, tag);
    modelStore(a, d);
    busValid = 1; busWrite = 1; busAddr = a; busData = d; scanCell = 13'(idx);
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  // monitor: one result per clock, one clock after each request
  always @(posedge clk) begin
    #1;
    if (qTag.size() > 0) begin
      logic [7:0] ec;
      logic [3:0] ek;
      int         ix;
      string      tg;
      ec = qChar.pop_front(); ek = qColor.pop_front();
      ix = qIdx.pop_front();  tg = qTag.pop_front();
      checks++;
      if (scanChar !== ec || scanColor !== ek) begin
        errors++;
        $display("FAIL %s cell %0d: actual char=%h color=%h expected char=%h color=%h",
                 tg, ix, scanChar, scanColor, ec, ek);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7500; i++) begin expChar[i] = 8'h20; expColor[i] = 4'h0; end
    rstN = 0; busValid = 0; busWrite = 0; busAddr = '0; busData = '0; scanCell = '0;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (10) @(negedge clk);
    // R10: stores during the clearing sweep (cell 5 already swept)
    sweepPhase = 1;
    store(CB + 5, 8'h51);
    store(KB + 5, 8'h0C);
    sweepPhase = 0;
    repeat (7600) @(negedge clk);

    // R1: every cell blank, back-to-back reads (R7)
    for (int i = 0; i < 7500; i++) scan(i, "R1");
    scan(5, "R10");

    // R2: row-major placement
    store(CB + 0,    8'h41);
    store(CB + 99,   8'h42);
    store(CB + 100,  8'h43);
    store(CB + 7499, 8'h44);
    store(CB + 12*100 + 37, 8'h45);
    scan(0, "R2"); scan(99, "R2"); scan(100, "R2"); scan(7499, "R2"); scan(1237, "R2");

    // R3: low nibble kept
    store(KB + 1237, 8'hA7);
    store(KB + 0,    8'hF3);
    store(KB + 7499, 8'h0F);
    scan(1237, "R3"); scan(0, "R3"); scan(7499, "R3");

    // R9: planes independent
    store(CB + 1237, 8'h46);
    scan(1237, "R9"); scan(99, "R9");

    // R4: loads ignored
    load(CB + 99, 8'h55);
    load(KB + 99, 8'h0F);
    scan(99, "R4");

    // R5: offsets past the last cell
    store(CB + 7500, 8'h77);
    store(CB + 8191, 8'h78);
    store(KB + 7500, 8'h09);
    store(KB + 8191, 8'h0A);
    scan(0, "R5"); scan(7499, "R5"); scan(7500 - 8192 + 8191, "R5");

    // R6: outside both windows
    store(32'h8000_BFFF, 8'h61);
    store(32'h8000_A005, 8'h62);
    store(32'h0000_C005, 8'h63);
    store(32'h9000_E005, 8'h0B);
    store(32'h8001_0005, 8'h64);
    scan(5, "R6"); scan(7499, "R6");

    // R7: interleaved back-to-back reads
    scan(99, "R7"); scan(100, "R7"); scan(99, "R7"); scan(7499, "R7");

    // R8: read during write returns old value
    storeScan(CB + 42, 8'h5A, 42, "R8");
    scan(42, "R8");
    storeScan(KB + 42, 8'h0E, 42, "R8");
    scan(42, "R8");

    // R11: out-of-range scan index
    scan(7500, "R11"); scan(8191, "R11");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule